// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two square-wave outputs of an incremental rotary encoder into a position count. Both lines are brought into the clock domain through a synchroniser chain. Their transitions are then classified. Each transition that counts produces a single-cycle strobe, a direction flag and a step of the position register. The register therefore holds the shaft angle directly, in units of counted edges.

A 2-bit mode input sets the resolution. The decoder can count transitions of channel B only, transitions of channel A only, or transitions of both channels. For every counted transition, the direction comes from the level of the channel that did not move. The decoder counts up when channel A leads channel B in phase. The position wraps inside a range set by a wrap-value input, so one revolution can map onto `0..wrap`. A cycle in which both synchronised lines change together is not a legal quadrature step, and it is discarded.

Top module: `qenc_position_top`

## Requirements
- R1: After synchronous reset, `position_o` is 0, `count_strobe_o` is 0 and `dir_up_o` is 1.
- R2: With `mode_i` = 2'b01, only transitions of channel B are counted. The count is up when the new B level equals the A level, and down otherwise.
- R3: With `mode_i` = 2'b10, only transitions of channel A are counted. The count is up when the new A level differs from the B level, and down otherwise.
- R4: With `mode_i` = 2'b11, transitions of both channels are counted, each by the direction rule of R2 or R3.
- R5: With `mode_i` = 2'b00, no transition is counted: there is no strobe and the position does not change.
- R6: When both synchronised channels change in the same cycle, there is no strobe and the position does not change.
- R7: Each counted transition raises `count_strobe_o` for exactly one cycle. On the next clock edge the position moves by one step in the signalled direction. While the strobe is low, the position holds.
- R8: A step up from a position greater than or equal to `wrap_val_i` gives 0.
- R9: A step down from 0 gives `wrap_val_i`.
- R10: `dir_up_o` shows the direction of the most recent counted transition and changes only together with a strobe.
- R11: Suppose an input level change is first sampled at clock edge k. The strobe is then high in the cycle that follows edge k+2, and the position is updated at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a_i | input | 1 | Raw encoder channel A |
| enc_b_i | input | 1 | Raw encoder channel B |
| mode_i | input | 2 | 00 off, 01 count B transitions, 10 count A transitions, 11 count both |
| wrap_val_i | input | CNT_W | Highest position value before wrap |
| count_strobe_o | output | 1 | One-cycle pulse per counted transition |
| dir_up_o | output | 1 | Direction of the last counted transition (1 = up) |
| position_o | output | CNT_W | Position counter |

## Verification
Two things can land in the same cycle. One is a transition of channel A together with a transition of channel B, which the decoder must reject. The other is a counted step together with the wrap boundary, which must roll over and not overflow. The random stimulus sometimes flips both lines at one falling clock edge, and the bench checks that no strobe appears and the position holds. Small wrap values are chosen so that random walks often cross both ends of the range. Each step's strobe count, cycle of arrival, direction and resulting position are compared with a model built from the phase rule and the wrap rule.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Bit 0 enables counting on B transitions, bit 1 on A transitions.
    typedef enum logic [1:0] {
        QM_OFF     = 2'b00,
        QM_EDGE_B  = 2'b01,
        QM_EDGE_A  = 2'b10,
        QM_EDGE_AB = 2'b11
    } qenc_mode_e;

    // Channel index within the synchronised level vector.
    localparam int CH_B = 0;
    localparam int CH_A = 1;

    typedef struct packed {
        logic fire;
        logic up;
    } qenc_evt_t;

    // A leading B: A rises while B is low, A falls while B is high.
    function automatic logic up_on_a_edge(input logic a_new, input logic b_lvl);
        return a_new != b_lvl;
    endfunction

    // A leading B: B rises while A is high, B falls while A is low.
    function automatic logic up_on_b_edge(input logic b_new, input logic a_lvl);
        return b_new == a_lvl;
    endfunction

    function automatic qenc_evt_t classify(input qenc_mode_e mode,
                                           input logic [1:0] cur,
                                           input logic [1:0] prv);
        qenc_evt_t  ev;
        logic [1:0] moved;
        moved   = cur ^ prv;
        ev.fire = 1'b0;
        ev.up   = 1'b0;
        unique case (moved)
            2'b10: begin
                ev.fire = mode[CH_A];
                ev.up   = up_on_a_edge(cur[CH_A], cur[CH_B]);
            end
            2'b01: begin
                ev.fire = mode[CH_B];
                ev.up   = up_on_b_edge(cur[CH_B], cur[CH_A]);
            end
            default: begin
                ev.fire = 1'b0;
                ev.up   = 1'b0;
            end
        endcase
        return ev;
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q_o = chain[LAST];
endmodule

// File: rtl/qenc_edge_decode.sv
module qenc_edge_decode
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] lvl_i,
    input  qenc_mode_e mode_i,
    output qenc_evt_t  evt_o,
    output logic       dir_up_o
);
    logic [1:0] prev_q;
    qenc_evt_t  evt_d;
    qenc_evt_t  evt_q;
    logic       dir_q;

    always_comb evt_d = classify(mode_i, lvl_i, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            evt_q  <= '0;
            dir_q  <= 1'b1;
        end else begin
            prev_q <= lvl_i;
            evt_q  <= evt_d;
            if (evt_d.fire) dir_q <= evt_d.up;
        end
    end

    assign evt_o    = evt_q;
    assign dir_up_o = dir_q;
endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  qenc_evt_t        step_i,
    input  logic [CNT_W-1:0] wrap_val_i,
    output logic [CNT_W-1:0] position_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] pos_d;

    always_comb begin
        pos_d = pos_q;
        if (step_i.fire) begin
            if (step_i.up) pos_d = (pos_q >= wrap_val_i) ? '0 : pos_q + ONE;
            else           pos_d = (pos_q == '0) ? wrap_val_i : pos_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= pos_d;
    end

    assign position_o = pos_q;
endmodule

// File: rtl/qenc_position_top.sv
module qenc_position_top
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_a_i,
    input  logic             enc_b_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] wrap_val_i,
    output logic             count_strobe_o,
    output logic             dir_up_o,
    output logic [CNT_W-1:0] position_o
);
    logic [1:0] raw_lvl;
    logic [1:0] sync_lvl;
    qenc_evt_t  evt;

    always_comb begin
        raw_lvl       = '0;
        raw_lvl[CH_A] = enc_a_i;
        raw_lvl[CH_B] = enc_b_i;
    end

    qenc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_lvl),
        .q_o (sync_lvl)
    );

    qenc_edge_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .lvl_i    (sync_lvl),
        .mode_i   (qenc_mode_e'(mode_i)),
        .evt_o    (evt),
        .dir_up_o (dir_up_o)
    );

    qenc_pos_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .step_i     (evt),
        .wrap_val_i (wrap_val_i),
        .position_o (position_o)
    );

    assign count_strobe_o = evt.fire;
endmodule

// File: rtl/qenc_position_checker.sv
module qenc_position_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_i,
    input logic [CNT_W-1:0] wrap_val_i,
    input logic             count_strobe_o,
    input logic             dir_up_o,
    input logic [CNT_W-1:0] position_o
);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !count_strobe_o |=> $stable(position_o));

    p_step_up_r7: assert property (@(posedge clk) disable iff (rst)
        count_strobe_o && dir_up_o && (position_o < wrap_val_i)
        |=> position_o == CNT_W'($past(position_o) + 1'b1));

    p_step_down_r7: assert property (@(posedge clk) disable iff (rst)
        count_strobe_o && !dir_up_o && (position_o != '0)
        |=> position_o == CNT_W'($past(position_o) - 1'b1));

    p_wrap_up_r8: assert property (@(posedge clk) disable iff (rst)
        count_strobe_o && dir_up_o && (position_o >= wrap_val_i)
        |=> position_o == '0);

    p_wrap_down_r9: assert property (@(posedge clk) disable iff (rst)
        count_strobe_o && !dir_up_o && (position_o == '0)
        |=> position_o == $past(wrap_val_i));

    p_dir_with_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(dir_up_o) |-> count_strobe_o);

    p_off_mode_r5: assert property (@(posedge clk) disable iff (rst)
        $past(mode_i) == 2'b00 |-> !count_strobe_o);
endmodule

bind qenc_position_top qenc_position_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .mode_i         (mode_i),
    .wrap_val_i     (wrap_val_i),
    .count_strobe_o (count_strobe_o),
    .dir_up_o       (dir_up_o),
    .position_o     (position_o)
);

// File: tb/qenc_position_top_tb.sv
module qenc_position_top_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enc_a = 1'b0;
    logic             enc_b = 1'b0;
    logic [1:0]       mode = 2'b11;
    logic [CNT_W-1:0] wrap_val = 16'd5;
    logic             strobe;
    logic             dir_up;
    logic [CNT_W-1:0] position;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    logic             m_a = 1'b0;
    logic             m_b = 1'b0;
    logic [CNT_W-1:0] m_pos = '0;
    logic             m_dir = 1'b1;

    always #2 clk = ~clk;

    qenc_position_top #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .enc_a_i        (enc_a),
        .enc_b_i        (enc_b),
        .mode_i         (mode),
        .wrap_val_i     (wrap_val),
        .count_strobe_o (strobe),
        .dir_up_o       (dir_up),
        .position_o     (position)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // returns {fire, up}
    function automatic logic [1:0] exp_event(input logic [1:0] md,
                                             input logic oa, input logic ob,
                                             input logic na, input logic nb);
        logic ca, cb;
        ca = oa ^ na;
        cb = ob ^ nb;
        if (ca && !cb) return {md[1], na != nb};
        if (cb && !ca) return {md[0], nb == na};
        return 2'b00;
    endfunction

    function automatic string mode_tag(input logic [1:0] md, input logic oa, input logic ob,
                                       input logic na, input logic nb);
        if ((oa ^ na) && (ob ^ nb)) return "R6";
        case (md)
            2'b01:   return "R2";
            2'b10:   return "R3";
            2'b11:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic step(input logic na, input logic nb);
        logic [1:0] ev;
        string      tag;
        string      ptag;
        int         pulses;
        int         first;
        ev  = exp_event(mode, m_a, m_b, na, nb);
        tag = mode_tag(mode, m_a, m_b, na, nb);
        ptag = "R7";
        if (ev[1]) begin
            m_dir = ev[0];
            if (ev[0]) begin
                if (m_pos >= wrap_val) begin m_pos = '0; ptag = "R8"; end
                else m_pos = m_pos + 1'b1;
            end else begin
                if (m_pos == '0) begin m_pos = wrap_val; ptag = "R9"; end
                else m_pos = m_pos - 1'b1;
            end
        end
        @(negedge clk);
        enc_a = na;
        enc_b = nb;
        m_a = na;
        m_b = nb;
        pulses = 0;
        first  = 0;
        for (int i = 1; i <= 6; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (strobe) begin
                pulses++;
                if (first == 0) first = i;
            end
        end
        chk({tag, " strobe count"}, pulses, ev[1] ? 1 : 0);
        if (ev[1]) chk("R11 strobe cycle", first, 3);
        chk({ptag, " position"}, position, m_pos);
        chk("R10 direction", dir_up, m_dir);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 position", position, 0);
        chk("R1 strobe", strobe, 0);
        chk("R1 direction", dir_up, 1);
        rst = 1'b0;

        // directed: full forward cycle A leading B, 4x mode, wrap at 5
        mode = 2'b11;
        step(1, 0); step(1, 1); step(0, 1); step(0, 0);
        step(1, 0); step(1, 1);                      // reaches 5 then wraps
        step(0, 1);
        // reverse back across 0
        step(1, 1); step(1, 0); step(0, 0); step(0, 1);
        // simultaneous change
        step(1, 0);
        // mode B-only: A transition ignored, B transition counted
        mode = 2'b01;
        step(0, 0); step(0, 1); step(1, 1);
        // mode A-only
        mode = 2'b10;
        step(1, 0); step(0, 0); step(0, 1);
        // off mode
        mode = 2'b00;
        step(1, 1); step(1, 0);
        step(0, 1);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int sel;
            if (n % 40 == 0) wrap_val = CNT_W'(3 + ($urandom % 18));
            if (n % 10 == 0) mode = 2'($urandom % 4);
            sel = $urandom % 16;
            if (sel < 7)       step(~m_a, m_b);
            else if (sel < 14) step(m_a, ~m_b);
            else if (sel < 15) step(~m_a, ~m_b);
            else               step(m_a, m_b);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule